// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

The block watches a received frame one byte per cycle while it streams past and reaches a single keep-or-drop verdict when the last byte arrives. Upstream logic marks the first byte with `sof_i`, the last byte with `eof_i`, and presents a frame-check verdict (`crc_ok_i`) together with the last byte. The CRC itself is computed outside the block. The block holds no frame data.

Six match criteria are evaluated in parallel, and each has its own enable bit. The criteria are: destination equal to the local address, a masked checksum over a 64-byte window at a programmable offset, a wake-up frame addressed to this station, a hash-table lookup on the destination, any group address, and the all-ones address. A mode input combines the enabled results with OR or with AND. A separate gate can veto any frame whose CRC flag is bad.

The verdict is registered. It appears with a one-cycle `done_o` strobe and then holds until the next verdict.

Top module: `eth_rx_filter`

## Requirements
- R1: `done_o` is high for exactly the cycle after a cycle with `valid_i` and `eof_i` both high, and at no other time. `accept_o` changes only together with a `done_o` strobe. Both outputs are 0 after reset.
- R2: The unicast result (enable bit 0) is true when the first six bytes of the frame equal `local_mac_i`, with the first byte compared against bits 47:40.
- R3: The group result (enable bit 4) is true when bit 0 of the first frame byte is 1.
- R4: The all-ones result (enable bit 5) is true when all six destination bytes are FFh.
- R5: The hash result (enable bit 3) is true when `hash_tbl_i[h]` is set. Here h is bits 28:23 of the frame CRC-32 of the six destination bytes: reflected polynomial EDB88320h, initial value all ones, bytes fed LSB first, final complement.
- R6: The pattern result (enable bit 1) covers frame bytes `pat_off_i` to `pat_off_i`+63. Window byte k is included when `pat_mask_i[k]` is set. Even k is the high byte of a 16-bit word and odd k the low byte. The included words are summed with one's-complement arithmetic. The result is true when the complement of that sum equals `pat_sum_i`. It is false if the frame ends before the window is complete.
- R7: The wake result (enable bit 2) needs the unicast match and, at or after byte 14, a run of six FFh bytes followed directly by sixteen back-to-back copies of the local address.
- R8: With `and_mode_i`=0, the frame is accepted if at least one enabled result is true.
- R9: With `and_mode_i`=1, the frame is accepted only if every enabled result is true.
- R10: With `en_i`=0, every frame is accepted, subject only to R11.
- R11: With `crc_chk_i`=1 and `crc_ok_i`=0 at the last byte, the frame is rejected whatever the other results are. With `crc_chk_i`=0, the CRC flag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A frame byte is present |
| sof_i | input | 1 | Current byte is the first of a frame |
| eof_i | input | 1 | Current byte is the last of a frame |
| data_i | input | 8 | Frame byte |
| crc_ok_i | input | 1 | Frame CRC good; sampled with the last byte |
| local_mac_i | input | 48 | Station address; bits 47:40 are sent first |
| en_i | input | 6 | Criterion enables: 0 unicast, 1 pattern, 2 wake, 3 hash, 4 group, 5 all-ones |
| and_mode_i | input | 1 | 1 = AND of enabled results, 0 = OR |
| crc_chk_i | input | 1 | Reject frames with a bad CRC |
| pat_off_i | input | IDX_W | First frame byte of the pattern window |
| pat_mask_i | input | WIN_BYTES | Byte include mask for the window |
| pat_sum_i | input | 16 | Expected window checksum |
| hash_tbl_i | input | HASH_BITS | Hash filter table |
| done_o | output | 1 | Verdict strobe |
| accept_o | output | 1 | Verdict, held until the next strobe |

## Verification
Single-criterion frames are run in pairs, a match and a near miss, so that each matcher is shown to respond to the feature it owns. Examples: the destination differs in one bit, the destination has a trailing FEh instead of FFh, and the hash table holds the chosen bit or every other bit. The pattern checksum is also tried with a wrong expected sum and with a frame that stops inside the window. The wake frame is tried with one corrupted address copy and with a foreign destination. Mixed enable sets separate OR from AND, and the CRC cases show the veto acting only when the gate is set.

// File: rtl/eth_filt_pkg.sv
package eth_filt_pkg;
  localparam int unsigned N_CRIT    = 6;
  localparam int unsigned MAC_BYTES = 6;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  typedef enum int unsigned {
    CR_UNI   = 0,
    CR_PAT   = 1,
    CR_MAGIC = 2,
    CR_HASH  = 3,
    CR_MCAST = 4,
    CR_BCAST = 5
  } crit_e;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/eth_filt_addr.sv
module eth_filt_addr
  import eth_filt_pkg::*;
#(
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned HASH_BITS = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 sof_i,
  input  logic [7:0]           data_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [47:0]          mac_i,
  input  logic [HASH_BITS-1:0] hash_tbl_i,
  output logic                 uni_o,
  output logic                 mcast_o,
  output logic                 bcast_o,
  output logic                 hash_o
);
  localparam int unsigned HASH_W = $clog2(HASH_BITS);

  logic        eq_q, ones_q, mc_q;
  logic [31:0] crc_q;
  logic        eq_c, ones_c, mc_c;
  logic [31:0] crc_c;
  logic        eq_n, ones_n, mc_n;
  logic [31:0] crc_n, chk;
  logic        in_da, full;
  logic [2:0]  sel, sel_inv;
  logic [7:0]  mbyte;

  always_comb begin
    eq_c   = sof_i ? 1'b1 : eq_q;
    ones_c = sof_i ? 1'b1 : ones_q;
    mc_c   = sof_i ? 1'b0 : mc_q;
    crc_c  = sof_i ? '1   : crc_q;
    in_da  = idx_i < IDX_W'(MAC_BYTES);
    full   = idx_i >= IDX_W'(MAC_BYTES - 1);
    sel    = in_da ? idx_i[2:0] : 3'd0;
    sel_inv = 3'd5 - sel;
    mbyte  = 8'(mac_i >> {sel_inv, 3'b000});
    eq_n = eq_c; ones_n = ones_c; mc_n = mc_c; crc_n = crc_c;
    if (in_da) begin
      eq_n   = eq_c & (data_i == mbyte);
      ones_n = ones_c & (data_i == 8'hFF);
      crc_n  = crc_step(crc_c, data_i);
      if (idx_i == '0) mc_n = data_i[0];
    end
    chk = ~crc_n;
  end

  assign uni_o   = full & eq_n;
  assign bcast_o = full & ones_n;
  assign mcast_o = mc_n;
  assign hash_o  = full & hash_tbl_i[chk[23 +: HASH_W]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_q <= 1'b0; ones_q <= 1'b0; mc_q <= 1'b0; crc_q <= '1;
    end else if (vld_i) begin
      eq_q <= eq_n; ones_q <= ones_n; mc_q <= mc_n; crc_q <= crc_n;
    end
  end
endmodule

// File: rtl/eth_filt_pattern.sv
module eth_filt_pattern #(
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned WIN_BYTES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 sof_i,
  input  logic [7:0]           data_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [IDX_W-1:0]     off_i,
  input  logic [WIN_BYTES-1:0] mask_i,
  input  logic [15:0]          sum_i,
  output logic                 match_o
);
  localparam int unsigned K_W = $clog2(WIN_BYTES);

  logic [15:0]    acc_q, acc_c, acc_n, word;
  logic           done_q, done_c, done_n;
  logic [IDX_W:0] rel;
  logic [K_W-1:0] k;
  logic           in_win;
  logic [16:0]    s17;

  always_comb begin
    acc_c  = sof_i ? 16'h0 : acc_q;
    done_c = sof_i ? 1'b0  : done_q;
    rel    = {1'b0, idx_i} - {1'b0, off_i};
    in_win = (idx_i >= off_i) && (rel < (IDX_W+1)'(WIN_BYTES));
    k      = rel[K_W-1:0];
    word   = k[0] ? {8'h00, data_i} : {data_i, 8'h00};
    s17    = {1'b0, acc_c} + {1'b0, word};
    acc_n  = acc_c;
    done_n = done_c;
    if (in_win) begin
      if (mask_i[k]) acc_n = s17[15:0] + 16'(s17[16]);  // end-around carry
      if (k == K_W'(WIN_BYTES - 1)) done_n = 1'b1;
    end
  end

  assign match_o = done_n & (~acc_n == sum_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0; done_q <= 1'b0;
    end else if (vld_i) begin
      acc_q <= acc_n; done_q <= done_n;
    end
  end
endmodule

// File: rtl/eth_filt_magic.sv
module eth_filt_magic #(
  parameter int unsigned IDX_W    = 11,
  parameter int unsigned DATA_OFS = 14,
  parameter int unsigned SYNC_LEN = 6,
  parameter int unsigned REPS     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic [7:0]       data_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [47:0]      mac_i,
  output logic             found_o
);
  localparam int unsigned FF_W  = $clog2(SYNC_LEN + 1);
  localparam int unsigned REP_W = $clog2(REPS);

  logic [FF_W-1:0]  ff_q, ff_c, ff_n;
  logic [REP_W-1:0] rep_q, rep_c, rep_n;
  logic [2:0]       col_q, col_c, col_n, col_inv;
  logic             run_q, run_c, run_n;
  logic             hit_q, hit_c, hit_n;
  logic [7:0]       exp_b;
  logic             is_ff;

  always_comb begin
    ff_c  = sof_i ? '0   : ff_q;
    rep_c = sof_i ? '0   : rep_q;
    col_c = sof_i ? 3'd0 : col_q;
    run_c = sof_i ? 1'b0 : run_q;
    hit_c = sof_i ? 1'b0 : hit_q;
    col_inv = 3'd5 - col_c;
    exp_b = 8'(mac_i >> {col_inv, 3'b000});
    is_ff = data_i == 8'hFF;
    ff_n = ff_c; rep_n = rep_c; col_n = col_c; run_n = run_c; hit_n = hit_c;
    if (idx_i >= IDX_W'(DATA_OFS) && !hit_c) begin
      if (run_c) begin
        if (data_i == exp_b) begin
          if (col_c == 3'd5) begin
            col_n = 3'd0;
            if (rep_c == REP_W'(REPS - 1)) begin
              hit_n = 1'b1; run_n = 1'b0;
            end else rep_n = rep_c + 1'b1;
          end else col_n = col_c + 3'd1;
        end else begin
          run_n = 1'b0;
          ff_n  = is_ff ? FF_W'(1) : '0;
        end
      end else if (is_ff) begin
        ff_n = (ff_c == FF_W'(SYNC_LEN)) ? ff_c : ff_c + 1'b1;
      end else if (ff_c == FF_W'(SYNC_LEN) && data_i == mac_i[47:40]) begin
        run_n = 1'b1; col_n = 3'd1; rep_n = '0; ff_n = '0;
      end else begin
        ff_n = '0;
      end
    end
  end

  assign found_o = hit_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= '0; rep_q <= '0; col_q <= 3'd0; run_q <= 1'b0; hit_q <= 1'b0;
    end else if (vld_i) begin
      ff_q <= ff_n; rep_q <= rep_n; col_q <= col_n; run_q <= run_n; hit_q <= hit_n;
    end
  end
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import eth_filt_pkg::*;
#(
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned HASH_BITS = 64,
  parameter int unsigned DATA_OFS  = 14,
  parameter int unsigned SYNC_LEN  = 6,
  parameter int unsigned REPS      = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 sof_i,
  input  logic                 eof_i,
  input  logic [7:0]           data_i,
  input  logic                 crc_ok_i,
  input  logic [47:0]          local_mac_i,
  input  logic [N_CRIT-1:0]    en_i,
  input  logic                 and_mode_i,
  input  logic                 crc_chk_i,
  input  logic [IDX_W-1:0]     pat_off_i,
  input  logic [WIN_BYTES-1:0] pat_mask_i,
  input  logic [15:0]          pat_sum_i,
  input  logic [HASH_BITS-1:0] hash_tbl_i,
  output logic                 done_o,
  output logic                 accept_o
);
  logic [IDX_W-1:0]  idx_q, idx_c;
  logic [N_CRIT-1:0] hit;
  logic              uni, mc, bc, hs, pm, wk;
  logic              verdict;

  assign idx_c = sof_i ? '0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (valid_i) idx_q <= (&idx_c) ? idx_c : idx_c + 1'b1;  // saturate
  end

  eth_filt_addr #(.IDX_W(IDX_W), .HASH_BITS(HASH_BITS)) u_addr (
    .clk_i, .rst_ni, .vld_i(valid_i), .sof_i, .data_i, .idx_i(idx_c),
    .mac_i(local_mac_i), .hash_tbl_i,
    .uni_o(uni), .mcast_o(mc), .bcast_o(bc), .hash_o(hs)
  );

  eth_filt_pattern #(.IDX_W(IDX_W), .WIN_BYTES(WIN_BYTES)) u_pat (
    .clk_i, .rst_ni, .vld_i(valid_i), .sof_i, .data_i, .idx_i(idx_c),
    .off_i(pat_off_i), .mask_i(pat_mask_i), .sum_i(pat_sum_i), .match_o(pm)
  );

  eth_filt_magic #(.IDX_W(IDX_W), .DATA_OFS(DATA_OFS), .SYNC_LEN(SYNC_LEN), .REPS(REPS)) u_wake (
    .clk_i, .rst_ni, .vld_i(valid_i), .sof_i, .data_i, .idx_i(idx_c),
    .mac_i(local_mac_i), .found_o(wk)
  );

  always_comb begin
    hit           = '0;
    hit[CR_UNI]   = uni;
    hit[CR_PAT]   = pm;
    hit[CR_MAGIC] = wk & uni;
    hit[CR_HASH]  = hs;
    hit[CR_MCAST] = mc;
    hit[CR_BCAST] = bc;
    if (en_i == '0)      verdict = 1'b1;
    else if (and_mode_i) verdict = &(hit | ~en_i);
    else                 verdict = |(hit & en_i);
    verdict = verdict & (~crc_chk_i | crc_ok_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0; accept_o <= 1'b0;
    end else begin
      done_o <= valid_i & eof_i;
      if (valid_i & eof_i) accept_o <= verdict;
    end
  end
endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk #(
  parameter int unsigned N_EN = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            eof_i,
  input logic [N_EN-1:0] en_i,
  input logic            crc_chk_i,
  input logic            crc_ok_i,
  input logic            done_o,
  input logic            accept_o
);
  p_done_after_eof_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && eof_i));

  p_eof_gives_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i) |=> done_o);

  p_accept_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && eof_i) |=> $stable(accept_o));

  p_crc_veto_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i && crc_chk_i && !crc_ok_i) |=> !accept_o);

  p_no_enable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eof_i && en_i == '0 && (!crc_chk_i || crc_ok_i)) |=> accept_o);
endmodule

bind eth_rx_filter eth_rx_filter_chk #(.N_EN(eth_filt_pkg::N_CRIT)) u_chk (.*);

// File: tb/eth_rx_filter_tb.sv
module eth_rx_filter_tb;
  localparam int unsigned IDX_W = 11;
  localparam logic [47:0] MAC = 48'h02_1A_3C_55_7E_91;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 0, sof = 0, eof = 0, crc_ok = 1, and_mode = 0, crc_chk = 0;
  logic [7:0]  data = 0;
  logic [5:0]  en = 0;
  logic [IDX_W-1:0] pat_off = 0;
  logic [63:0] pat_mask = 0, hash_tbl = 0;
  logic [15:0] pat_sum = 0;
  logic done, accept;

  int n_chk = 0, n_bad = 0;
  logic [7:0] frm [0:255];

  always #5 clk = ~clk;

  eth_rx_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .eof_i(eof),
    .data_i(data), .crc_ok_i(crc_ok), .local_mac_i(MAC), .en_i(en),
    .and_mode_i(and_mode), .crc_chk_i(crc_chk), .pat_off_i(pat_off),
    .pat_mask_i(pat_mask), .pat_sum_i(pat_sum), .hash_tbl_i(hash_tbl),
    .done_o(done), .accept_o(accept)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic fill(input int len, input logic [47:0] da);
    for (int i = 0; i < len; i++) frm[i] = 8'((i * 7 + 3) & 8'h7F);
    for (int i = 0; i < 6; i++) frm[i] = 8'(da >> (8 * (5 - i)));
  endtask

  task automatic send(input int len, input logic exp, input string tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      valid = 1; sof = (i == 0); eof = (i == len - 1); data = frm[i];
    end
    @(negedge clk);
    valid = 0; sof = 0; eof = 0;
    check(done, 1'b1, {tag, " done"});
    check(accept, exp, tag);
  endtask

  task automatic cfg_clear();
    en = 0; and_mode = 0; crc_chk = 0; crc_ok = 1;
  endtask

  function automatic logic [5:0] hash_of(input logic [47:0] da);
    logic [31:0] c;
    logic [7:0] b;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      b = 8'(da >> (8 * (5 - i)));
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ b[j]) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    end
    c = ~c;
    return c[28:23];
  endfunction

  function automatic logic [15:0] pat_of(input int off, input logic [63:0] m);
    logic [16:0] s;
    logic [15:0] a;
    a = 0;
    for (int k = 0; k < 64; k++) begin
      if (m[k]) begin
        s = {1'b0, a} + (k % 2 == 0 ? {1'b0, frm[off + k], 8'h00} : {9'h0, frm[off + k]});
        a = s[15:0] + {15'h0, s[16]};
      end
    end
    return ~a;
  endfunction

  task automatic t_reset();
    check(done, 1'b0, "R1 reset done");
    check(accept, 1'b0, "R1 reset accept");
  endtask

  task automatic t_unicast();
    cfg_clear(); en = 6'b000001;
    fill(64, MAC); send(64, 1'b1, "R2 own address");
    fill(64, MAC ^ 48'h1); send(64, 1'b0, "R2 other address");
  endtask

  task automatic t_group();
    cfg_clear(); en = 6'b010000;
    fill(64, 48'h01_00_5E_00_00_07); send(64, 1'b1, "R3 group address");
    fill(64, MAC); send(64, 1'b0, "R3 individual address");
  endtask

  task automatic t_bcast();
    cfg_clear(); en = 6'b100000;
    fill(64, '1); send(64, 1'b1, "R4 all ones");
    fill(64, 48'hFFFF_FFFF_FFFE); send(64, 1'b0, "R4 last byte FE");
  endtask

  task automatic t_hash();
    logic [47:0] da;
    da = 48'h33_33_00_00_00_FB;
    cfg_clear(); en = 6'b001000;
    hash_tbl = 64'h1 << hash_of(da);
    fill(64, da); send(64, 1'b1, "R5 table bit set");
    hash_tbl = ~(64'h1 << hash_of(da));
    send(64, 1'b0, "R5 table bit clear");
  endtask

  task automatic t_pattern();
    cfg_clear(); en = 6'b000010;
    pat_off = 11'd4; pat_mask = 64'hF0F0_0003_8000_10FF;
    fill(80, MAC);
    pat_sum = pat_of(4, pat_mask);
    send(80, 1'b1, "R6 checksum equal");
    pat_sum = pat_sum ^ 16'h0100;
    send(80, 1'b0, "R6 checksum differs");
    pat_sum = pat_sum ^ 16'h0100;
    send(40, 1'b0, "R6 frame ends inside window");
  endtask

  task automatic build_wake();
    fill(124, MAC);
    for (int i = 18; i < 24; i++) frm[i] = 8'hFF;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 6; c++) frm[24 + 6 * r + c] = 8'(MAC >> (8 * (5 - c)));
  endtask

  task automatic t_wake();
    cfg_clear(); en = 6'b000100;
    build_wake(); send(124, 1'b1, "R7 wake frame");
    frm[74] = frm[74] ^ 8'h01; send(124, 1'b0, "R7 corrupted copy");
    build_wake(); frm[0] = frm[0] ^ 8'h04; send(124, 1'b0, "R7 foreign destination");
  endtask

  task automatic t_modes();
    cfg_clear(); en = 6'b100001;
    fill(64, '1); send(64, 1'b1, "R8 OR one of two");
    fill(64, 48'h02_00_00_00_00_09); send(64, 1'b0, "R8 OR none");
    and_mode = 1; en = 6'b010001;
    fill(64, MAC); send(64, 1'b0, "R9 AND one of two");
    en = 6'b110000;
    fill(64, '1); send(64, 1'b1, "R9 AND both");
  endtask

  task automatic t_none();
    cfg_clear();
    fill(20, 48'h02_00_00_00_00_09); send(20, 1'b1, "R10 no enables");
  endtask

  task automatic t_crc();
    cfg_clear(); crc_chk = 1; crc_ok = 0;
    fill(64, MAC); send(64, 1'b0, "R11 gate bad crc");
    en = 6'b000001; send(64, 1'b0, "R11 gate bad crc with match");
    crc_ok = 1; send(64, 1'b1, "R11 gate good crc");
    crc_chk = 0; crc_ok = 0; send(64, 1'b1, "R11 gate off");
  endtask

  task automatic t_hold();
    cfg_clear(); en = 6'b000001;
    fill(64, MAC); send(64, 1'b1, "R1 verdict");
    repeat (5) @(negedge clk);
    check(done, 1'b0, "R1 strobe low after");
    check(accept, 1'b1, "R1 verdict held");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unicast();
    t_group();
    t_bcast();
    t_hash();
    t_pattern();
    t_wake();
    t_modes();
    t_none();
    t_crc();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule